// File: doc/BRIEF.md
# Read-to-Write Address Coupler

This block sits in a memory-to-memory copy engine, between the stream of write-address requests the engine generates and the write-address channel of the bus. It watches the read data channel of the same engine. A request that carries the wait-for-read option is held back until the first data beat of its own read burst has been accepted. A write port is then claimed only once data exists to fill it. A request without the option is forwarded at once, as long as nothing is queued ahead of it.

Read bursts and write addresses belong to the same ordered stream of transfers. The block pairs them by position. A signed balance counts first read beats seen minus write addresses released. A held request at the head of the queue may leave only when that balance is positive, which means the first beat of its own burst has arrived. Pending requests wait in a small in-order queue and a busy flag reports that the queue is not empty. A build parameter can remove the coupling entirely, which leaves plain wires.

Top module: `rw_addr_coupler`

## Requirements
- R1: A request accepted with `wa_wait_rd_i`=1 is not offered on the output until the first read beat of its burst has handshaken. It is offered at the earliest in the cycle after the clock edge on which that beat was accepted, or in the cycle after its own acceptance if the beat came earlier.
- R2: First read beats pair with write addresses in acceptance order, counting held and unheld requests alike. The n-th first beat since reset releases only the n-th request.
- R3: A first beat is the first cycle with `rd_valid_i`=1 and `rd_ready_i`=1 after reset or after an accepted beat with `rd_last_i`=1. Later beats of the same burst, and cycles where valid is not matched by ready, release nothing.
- R4: When the queue is empty and `wa_wait_rd_i`=0, the input is connected straight to the output in the same cycle: the output valid follows the input valid, the address and length pass through, and `wa_ready_o` follows `wa_ready_i`.
- R5: Requests leave in the order they were accepted. An unheld request queued behind a held one waits for it.
- R6: `busy_o` is 1 exactly while the queue holds at least one request, and 0 after reset.
- R7: The queue holds `Depth` requests. When it is full, `wa_ready_o` is 0.
- R8: With `CouplingEn`=0 the output equals the input in every cycle, whatever the option bit and read channel do, and `busy_o` stays 0.
- R9: A queued request offered on the output keeps valid, address and length stable until it is accepted.
- R10: After reset, with no input valid, the output valid is 0, `busy_o` is 0 and `wa_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wa_valid_i | input | 1 | Incoming write-address request valid |
| wa_ready_o | output | 1 | Incoming request accepted |
| wa_addr_i | input | AddrW | Incoming write address |
| wa_len_i | input | LenW | Incoming burst length field |
| wa_wait_rd_i | input | 1 | Option: 1 holds this request until its first read beat |
| wa_valid_o | output | 1 | Outgoing write-address valid |
| wa_ready_i | input | 1 | Bus accepts the outgoing address |
| wa_addr_o | output | AddrW | Outgoing write address |
| wa_len_o | output | LenW | Outgoing burst length field |
| rd_valid_i | input | 1 | Observed read data valid |
| rd_ready_i | input | 1 | Observed read data ready |
| rd_last_i | input | 1 | Observed read data last-beat marker |
| busy_o | output | 1 | Queue holds pending requests |

## Verification
The bench builds the coupled instance with a queue depth of 2, a 12-bit address and a 4-bit length. At that depth, full-queue back-pressure and order blocking behind a held head take only a few requests to reach. It sweeps the gap between a held request and its first read beat from zero to three cycles, and it also covers a read that arrives before its address. It drives unheld requests through both the bypass and the queue, so that the negative balance and the pairing by position are exercised. A second instance built with `CouplingEn`=0 sees the same stimulus and shows the pure wire behaviour.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

   // How a write address left the block in a given cycle
   typedef enum logic [1:0] {
      RWC_IDLE,
      RWC_BYPASS,
      RWC_FREE,
      RWC_PAIRED
   } rwc_rel_e;

   // Bits needed to count 0..n inclusive
   function automatic int unsigned rwc_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rwc_first_beat.sv
module rwc_first_beat (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic beat_vld_i,
   input  logic beat_rdy_i,
   input  logic beat_last_i,
   output logic first_o
);

   logic expect_first_q;
   logic beat_fire;

   assign beat_fire = beat_vld_i & beat_rdy_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         expect_first_q <= 1'b1;
      end else if (beat_fire) begin
         expect_first_q <= beat_last_i;
      end
   end

   assign first_o = beat_fire & expect_first_q;

endmodule

// File: rtl/rwc_balance.sv
module rwc_balance #(
   parameter int unsigned BalW = 5
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   inc_i,
   input  logic                   dec_i,
   output logic signed [BalW-1:0] bal_o,
   output logic                   ahead_o
);

   localparam logic signed [BalW-1:0] One = BalW'(1);

   logic signed [BalW-1:0] bal_q;
   logic signed [BalW-1:0] bal_d;

   always_comb begin
      unique case ({inc_i, dec_i})
         2'b10:   bal_d = bal_q + One;
         2'b01:   bal_d = bal_q - One;
         default: bal_d = bal_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bal_q <= '0;
      end else begin
         bal_q <= bal_d;
      end
   end

   assign bal_o   = bal_q;
   assign ahead_o = (bal_q > 0);

endmodule

// File: rtl/rwc_aw_queue.sv
module rwc_aw_queue #(
   parameter int unsigned Width = 8,
   parameter int unsigned Depth = 2,
   localparam int unsigned PtrW = (Depth > 1) ? $clog2(Depth) : 1,
   localparam int unsigned CntW = rwc_pkg::rwc_cnt_w(Depth)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [Width-1:0] wdata_i,
   input  logic             pop_i,
   output logic [Width-1:0] rdata_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CntW-1:0]  cnt_o
);

   localparam logic [PtrW-1:0] LastPtr = PtrW'(Depth - 1);
   localparam logic [CntW-1:0] FullCnt = CntW'(Depth);

   logic [Width-1:0] slot_q [Depth];
   logic [PtrW-1:0]  wr_ptr_q, rd_ptr_q;
   logic [CntW-1:0]  cnt_q;

   function automatic logic [PtrW-1:0] bump(input logic [PtrW-1:0] p);
      return (p == LastPtr) ? '0 : p + PtrW'(1);
   endfunction

   for (genvar g = 0; g < Depth; g++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (push_i && (wr_ptr_q == PtrW'(g))) begin
            slot_q[g] <= wdata_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_i) wr_ptr_q <= bump(wr_ptr_q);
         if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
         if (push_i && !pop_i)      cnt_q <= cnt_q + CntW'(1);
         else if (pop_i && !push_i) cnt_q <= cnt_q - CntW'(1);
      end
   end

   assign rdata_o = slot_q[rd_ptr_q];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == FullCnt);
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/rw_addr_coupler.sv
module rw_addr_coupler #(
   parameter int unsigned AddrW      = 32,
   parameter int unsigned LenW       = 8,
   parameter int unsigned Depth      = 4,
   parameter int unsigned MaxAhead   = 8,
   parameter bit          CouplingEn = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wa_valid_i,
   output logic             wa_ready_o,
   input  logic [AddrW-1:0] wa_addr_i,
   input  logic [LenW-1:0]  wa_len_i,
   input  logic             wa_wait_rd_i,
   output logic             wa_valid_o,
   input  logic             wa_ready_i,
   output logic [AddrW-1:0] wa_addr_o,
   output logic [LenW-1:0]  wa_len_o,
   input  logic             rd_valid_i,
   input  logic             rd_ready_i,
   input  logic             rd_last_i,
   output logic             busy_o
);
   import rwc_pkg::*;

   localparam int unsigned EntryW = AddrW + LenW + 1;
   localparam int unsigned CntW   = rwc_cnt_w(Depth);
   localparam int unsigned BalW   = rwc_cnt_w(MaxAhead) + 1;

   if (Depth < 1)        $error("rw_addr_coupler: Depth must be at least 1");
   if (AddrW < 1)        $error("rw_addr_coupler: AddrW must be at least 1");
   if (LenW < 1)         $error("rw_addr_coupler: LenW must be at least 1");
   if (MaxAhead < Depth) $error("rw_addr_coupler: MaxAhead must cover Depth");

   // Shared between both variants so the checker sees one set of names
   logic [CntW-1:0]        q_cnt;
   logic signed [BalW-1:0] bal_q;
   logic                   head_hold;
   logic                   bypass;

   if (CouplingEn) begin : g_coupled
      logic              first_beat;
      logic              data_ahead;
      logic              q_push, q_pop, q_empty, q_full;
      logic [EntryW-1:0] q_wdata, q_rdata;
      logic [AddrW-1:0]  head_addr;
      logic [LenW-1:0]   head_len;
      logic              head_go;
      rwc_rel_e          rel_kind;

      rwc_first_beat u_first (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .beat_vld_i  (rd_valid_i),
         .beat_rdy_i  (rd_ready_i),
         .beat_last_i (rd_last_i),
         .first_o     (first_beat)
      );

      rwc_balance #(.BalW(BalW)) u_bal (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .inc_i   (first_beat),
         .dec_i   (rel_kind != RWC_IDLE),
         .bal_o   (bal_q),
         .ahead_o (data_ahead)
      );

      assign q_wdata = {wa_wait_rd_i, wa_len_i, wa_addr_i};

      rwc_aw_queue #(.Width(EntryW), .Depth(Depth)) u_queue (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .push_i  (q_push),
         .wdata_i (q_wdata),
         .pop_i   (q_pop),
         .rdata_o (q_rdata),
         .empty_o (q_empty),
         .full_o  (q_full),
         .cnt_o   (q_cnt)
      );

      assign head_hold = q_rdata[EntryW-1];
      assign head_len  = q_rdata[AddrW +: LenW];
      assign head_addr = q_rdata[AddrW-1:0];

      assign bypass  = q_empty & ~wa_wait_rd_i;
      assign head_go = ~q_empty & (~head_hold | data_ahead);

      assign wa_valid_o = bypass ? wa_valid_i : head_go;
      assign wa_addr_o  = bypass ? wa_addr_i  : head_addr;
      assign wa_len_o   = bypass ? wa_len_i   : head_len;
      assign wa_ready_o = bypass ? wa_ready_i : ~q_full;

      assign q_push = wa_valid_i & ~bypass & ~q_full;
      assign q_pop  = head_go & wa_ready_i;

      always_comb begin
         rel_kind = RWC_IDLE;
         if (wa_valid_o && wa_ready_i) begin
            if (bypass)         rel_kind = RWC_BYPASS;
            else if (head_hold) rel_kind = RWC_PAIRED;
            else                rel_kind = RWC_FREE;
         end
      end

      assign busy_o = ~q_empty;
   end else begin : g_wire
      assign wa_valid_o = wa_valid_i;
      assign wa_addr_o  = wa_addr_i;
      assign wa_len_o   = wa_len_i;
      assign wa_ready_o = wa_ready_i;
      assign busy_o     = 1'b0;
      assign q_cnt      = '0;
      assign bal_q      = '0;
      assign head_hold  = 1'b0;
      assign bypass     = 1'b1;
   end

endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
   parameter int unsigned AddrW = 32,
   parameter int unsigned LenW  = 8,
   parameter int unsigned Depth = 4,
   parameter int unsigned CntW  = 3,
   parameter int unsigned BalW  = 5
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   wa_valid_i,
   input logic                   wa_ready_o,
   input logic                   wa_wait_rd_i,
   input logic                   wa_valid_o,
   input logic                   wa_ready_i,
   input logic [AddrW-1:0]       wa_addr_o,
   input logic [LenW-1:0]        wa_len_o,
   input logic                   busy_o,
   input logic [CntW-1:0]        q_cnt,
   input logic signed [BalW-1:0] bal_q,
   input logic                   head_hold,
   input logic                   bypass
);

   // R1
   held_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wa_valid_o && wa_ready_i && busy_o && head_hold) |-> (bal_q > 0));

   // R4
   pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && wa_valid_i && !wa_wait_rd_i) |-> wa_valid_o);

   // R6
   push_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wa_valid_i && wa_ready_o && !bypass) |=> busy_o);

   // R7
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wa_valid_i && wa_ready_o && !bypass) |-> (q_cnt < CntW'(Depth)));

   // R9
   offer_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && wa_valid_o && !wa_ready_i) |=>
         (wa_valid_o && $stable(wa_addr_o) && $stable(wa_len_o)));

endmodule

bind rw_addr_coupler rwc_checker #(
   .AddrW (AddrW),
   .LenW  (LenW),
   .Depth (Depth),
   .CntW  (CntW),
   .BalW  (BalW)
) u_rwc_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wa_valid_i   (wa_valid_i),
   .wa_ready_o   (wa_ready_o),
   .wa_wait_rd_i (wa_wait_rd_i),
   .wa_valid_o   (wa_valid_o),
   .wa_ready_i   (wa_ready_i),
   .wa_addr_o    (wa_addr_o),
   .wa_len_o     (wa_len_o),
   .busy_o       (busy_o),
   .q_cnt        (q_cnt),
   .bal_q        (bal_q),
   .head_hold    (head_hold),
   .bypass       (bypass)
);

// File: tb/tb_rw_addr_coupler.sv
module tb_rw_addr_coupler;

   localparam int unsigned AW = 12;
   localparam int unsigned LW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_vld, in_hold, out_rdy;
   logic [AW-1:0] in_addr;
   logic [LW-1:0] in_len;
   logic          rd_vld, rd_rdy, rd_last;

   logic          in_rdy, out_vld, busy;
   logic [AW-1:0] out_addr;
   logic [LW-1:0] out_len;
   logic          pt_in_rdy, pt_out_vld, pt_busy;
   logic [AW-1:0] pt_addr;
   logic [LW-1:0] pt_len;

   int nchk  = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   rw_addr_coupler #(.AddrW(AW), .LenW(LW), .Depth(2), .MaxAhead(4), .CouplingEn(1'b1)) dut (
      .clk_i(clk), .rst_ni(rst_n),
      .wa_valid_i(in_vld), .wa_ready_o(in_rdy), .wa_addr_i(in_addr), .wa_len_i(in_len),
      .wa_wait_rd_i(in_hold),
      .wa_valid_o(out_vld), .wa_ready_i(out_rdy), .wa_addr_o(out_addr), .wa_len_o(out_len),
      .rd_valid_i(rd_vld), .rd_ready_i(rd_rdy), .rd_last_i(rd_last),
      .busy_o(busy)
   );

   rw_addr_coupler #(.AddrW(AW), .LenW(LW), .Depth(2), .MaxAhead(4), .CouplingEn(1'b0)) dut_pt (
      .clk_i(clk), .rst_ni(rst_n),
      .wa_valid_i(in_vld), .wa_ready_o(pt_in_rdy), .wa_addr_i(in_addr), .wa_len_i(in_len),
      .wa_wait_rd_i(in_hold),
      .wa_valid_o(pt_out_vld), .wa_ready_i(out_rdy), .wa_addr_o(pt_addr), .wa_len_o(pt_len),
      .rd_valid_i(rd_vld), .rd_ready_i(rd_rdy), .rd_last_i(rd_last),
      .busy_o(pt_busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      in_vld  = 1'b0;
      in_hold = 1'b0;
      rd_vld  = 1'b0;
      rd_last = 1'b0;
   endtask

   task automatic push(input logic hold, input logic [AW-1:0] a, input logic [LW-1:0] l);
      in_vld  = 1'b1;
      in_hold = hold;
      in_addr = a;
      in_len  = l;
      step();
      in_vld  = 1'b0;
      in_hold = 1'b0;
   endtask

   task automatic beat(input logic last);
      rd_vld  = 1'b1;
      rd_last = last;
      step();
      rd_vld  = 1'b0;
      rd_last = 1'b0;
      #1;
   endtask

   initial begin
      #(8 * 20000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      out_rdy = 1'b1;
      rd_rdy  = 1'b1;
      in_addr = '0;
      in_len  = '0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      check("R10 out_valid", 32'(out_vld), 32'd0);
      check("R10 busy", 32'(busy), 32'd0);
      check("R10 in_ready", 32'(in_rdy), 32'd1);

      // R4 bypass
      in_vld = 1'b1; in_hold = 1'b0; in_addr = 12'h123; in_len = 4'h3;
      #1;
      check("R4 valid", 32'(out_vld), 32'd1);
      check("R4 addr", 32'(out_addr), 32'h123);
      check("R4 len", 32'(out_len), 32'h3);
      check("R4 ready", 32'(in_rdy), 32'd1);
      out_rdy = 1'b0; #1;
      check("R4 ready follows", 32'(in_rdy), 32'd0);
      out_rdy = 1'b1;
      step();
      idle();
      beat(1'b1);   // read burst of the bypassed request

      // R1 / R8 held request, R6 busy
      in_vld = 1'b1; in_hold = 1'b1; in_addr = 12'h200; in_len = 4'h1;
      #1;
      check("R1 held not offered", 32'(out_vld), 32'd0);
      check("R8 wire valid", 32'(pt_out_vld), 32'd1);
      check("R8 wire addr", 32'(pt_addr), 32'h200);
      check("R8 wire busy", 32'(pt_busy), 32'd0);
      step();
      idle(); #1;
      check("R6 busy set", 32'(busy), 32'd1);
      for (int i = 0; i < 3; i++) begin
         step();
         check("R1 still held", 32'(out_vld), 32'd0);
      end
      rd_rdy = 1'b0; rd_vld = 1'b1; rd_last = 1'b0;
      step(); #1;
      check("R3 no handshake", 32'(out_vld), 32'd0);
      rd_rdy = 1'b1;
      beat(1'b0);
      check("R1 released", 32'(out_vld), 32'd1);
      check("R1 addr", 32'(out_addr), 32'h200);
      step(); #1;
      check("R6 busy clear", 32'(busy), 32'd0);

      // R3 beats inside a burst release nothing
      push(1'b1, 12'h300, 4'h2);
      beat(1'b0);
      check("R3 mid burst", 32'(out_vld), 32'd0);
      beat(1'b1);
      check("R3 last beat", 32'(out_vld), 32'd0);
      beat(1'b1);
      check("R3 new first", 32'(out_vld), 32'd1);
      check("R3 addr", 32'(out_addr), 32'h300);
      step();

      // R1 sweep of the gap between request and first beat
      for (int d = 0; d < 4; d++) begin
         push(1'b1, 12'h500 + 12'(d), 4'(d));
         for (int k = 0; k < d; k++) begin
            step();
            check("R1 sweep wait", 32'(out_vld), 32'd0);
         end
         rd_vld = 1'b1; rd_last = 1'b1; #1;
         check("R1 sweep before edge", 32'(out_vld), 32'd0);
         step();
         rd_vld = 1'b0; rd_last = 1'b0; #1;
         check("R1 sweep valid", 32'(out_vld), 32'd1);
         check("R1 sweep addr", 32'(out_addr), 32'(12'h500 + 12'(d)));
         check("R1 sweep len", 32'(out_len), 32'(d));
         step(); #1;
         check("R6 sweep busy", 32'(busy), 32'd0);
      end

      // R1 read arrives before its address
      beat(1'b1);
      check("R1 early read idle", 32'(out_vld), 32'd0);
      in_vld = 1'b1; in_hold = 1'b1; in_addr = 12'h5A0; in_len = 4'h4; #1;
      check("R1 early same cycle", 32'(out_vld), 32'd0);
      step();
      idle(); #1;
      check("R1 early next cycle", 32'(out_vld), 32'd1);
      check("R1 early addr", 32'(out_addr), 32'h5A0);
      step();

      // R5 / R7 / R9 order, capacity, stability
      out_rdy = 1'b0;
      push(1'b1, 12'h400, 4'h0);
      push(1'b0, 12'h401, 4'h7);
      in_vld = 1'b1; in_hold = 1'b0; in_addr = 12'h402; #1;
      check("R7 full ready", 32'(in_rdy), 32'd0);
      check("R5 unheld waits", 32'(out_vld), 32'd0);
      idle();
      beat(1'b1);
      check("R5 head first", 32'(out_addr), 32'h400);
      check("R5 head valid", 32'(out_vld), 32'd1);
      step(); #1;
      check("R9 valid kept", 32'(out_vld), 32'd1);
      check("R9 addr kept", 32'(out_addr), 32'h400);
      out_rdy = 1'b1;
      step(); #1;
      check("R5 second valid", 32'(out_vld), 32'd1);
      check("R5 second addr", 32'(out_addr), 32'h401);
      check("R5 second len", 32'(out_len), 32'h7);
      step(); #1;
      check("R6 drained", 32'(busy), 32'd0);
      beat(1'b1);   // read burst of the unheld request

      // R2 pairing by position
      push(1'b0, 12'h600, 4'h1);
      push(1'b1, 12'h601, 4'h2);
      beat(1'b1);
      check("R2 beat of earlier", 32'(out_vld), 32'd0);
      beat(1'b1);
      check("R2 own beat", 32'(out_vld), 32'd1);
      check("R2 addr", 32'(out_addr), 32'h601);
      step(); #1;
      check("R8 wire busy end", 32'(pt_busy), 32'd0);
      check("R8 wire ready", 32'(pt_in_rdy), 32'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule